// File: doc/BRIEF.md
# Three-Phase Sequencer for an Accumulator Microcontroller

This block is the control unit of a small non-pipelined accumulator machine with 12-bit instruction words. After reset it sits in a program-load phase. In that phase it drives the strobe that writes instruction words into program memory, one word per cycle. When the loader reports that it is done, the unit clears the programmer context and starts a fixed three-cycle loop: fetch, decode, execute.

Each cycle it looks at its phase and at the instruction register. From these it drives the enables of the program counter, accumulator, flag register, instruction register and operand register. It also drives the program and data memory enables, the data memory write enable, the ALU enable and mode, the select that picks the next program counter, and the select for the ALU's second operand. Conditional branches test one flag bit picked by the instruction. All outputs are combinational functions of the phase register and the inputs, so the datapath acts on them at the next rising edge.

Top module: `mcc_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the unit in the load phase at the next rising edge. The load phase also holds from then on until a load-done pulse arrives.
- R2: In the load phase, `prog_wr_en` and `prog_rd_en` are 1 and every other output is 0, except `ctx_clear`. `ctx_clear` is 1 only in a load-phase cycle where `load_done` is 1, and that rising edge moves the unit to fetch. Outside the load phase, `prog_wr_en` and `ctx_clear` are 0.
- R3: In fetch, `ir_en` and `prog_rd_en` are 1 and all other outputs are 0, whatever the instruction.
- R4: In decode, `dr_en` and `dmem_en` are 1 when `ir[11:9]` = 001 (the memory-operand ALU class), and all other outputs are 0. For every other instruction, all outputs are 0 in decode.
- R5: In execute, `pc_en` is 1 for every instruction. The no-operation class (`ir[11:8]` = 0000) and both ALU classes set `pc_jump` = 0, which selects PC+1.
- R6: In execute, the unconditional jump (`ir[11:8]` = 0001) sets `pc_jump` = 1, which selects the target `ir[7:0]`.
- R7: In execute, the conditional branch class (`ir[11:10]` = 01) sets `pc_jump` to a flag bit picked by `ir[9:8]`. Code 0 tests `sr[3]` (zero), 1 tests `sr[2]` (carry), 2 tests `sr[1]` (sign) and 3 tests `sr[0]` (overflow).
- R8: In execute for the memory-operand class, the outputs are `alu_en` = 1, `flags_en` = 1, `op2_from_dr` = 1 and `alu_mode` = `ir[7:4]`. If `ir[8]` = 1, `acc_en` = 1 and the data memory strobes are 0. If `ir[8]` = 0, `dmem_en` = `dmem_we` = 1 and `acc_en` = 0.
- R9: In execute for the immediate ALU class (`ir[11]` = 1), the outputs are `alu_en`, `acc_en` and `flags_en` = 1, `op2_from_dr` = 0 (immediate operand) and `alu_mode` = {0, `ir[10:8]`}. The data memory strobes are 0.
- R10: The phases run fetch, decode, execute, fetch, so each instruction takes exactly three cycles. `load_done` has no effect outside the load phase.
- R11: Any output that the current phase and instruction do not use is 0. This includes `alu_mode` and `op2_from_dr` whenever `alu_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_done | input | 1 | One-cycle pulse ending program load |
| ir | input | 12 | Instruction register contents |
| sr | input | 4 | Flags: [3] zero, [2] carry, [1] sign, [0] overflow |
| prog_wr_en | output | 1 | Program memory load strobe |
| prog_rd_en | output | 1 | Program memory enable |
| pc_en | output | 1 | Program counter update enable |
| acc_en | output | 1 | Accumulator update enable |
| flags_en | output | 1 | Flag register update enable |
| ir_en | output | 1 | Instruction register update enable |
| dr_en | output | 1 | Operand register update enable |
| dmem_en | output | 1 | Data memory enable |
| dmem_we | output | 1 | Data memory write enable |
| alu_en | output | 1 | ALU enable |
| alu_mode | output | 4 | ALU operation code |
| pc_jump | output | 1 | 1: PC loads ir[7:0]; 0: PC increments |
| op2_from_dr | output | 1 | 1: operand 2 from DR; 0: from ir[7:0] |
| ctx_clear | output | 1 | Clear PC, IR, DR, Acc and flags at this edge |

## Verification
Every output is combinational, so a change in `ir`, `sr` or `load_done` shows in the same cycle. The bench drives these inputs just after a falling edge and samples the outputs one time unit later, well before the next rising edge. A change of phase shows only after one rising edge. The bench therefore advances its own phase model at each rising edge, from the inputs held across that edge, and compares against that model in the following cycle. Resets and load-done pulses are scattered through random instruction and flag patterns. This exercises the rule that a load-done pulse outside the load phase is ignored, and the three-cycle cadence restarting after each reset.

// File: rtl/mcc_ctrl.sv
module mcc_ctrl (
  input  logic        clk,
  input  logic        rst,
  input  logic        load_done,
  input  logic [11:0] ir,
  input  logic [3:0]  sr,
  output logic        prog_wr_en,
  output logic        prog_rd_en,
  output logic        pc_en,
  output logic        acc_en,
  output logic        flags_en,
  output logic        ir_en,
  output logic        dr_en,
  output logic        dmem_en,
  output logic        dmem_we,
  output logic        alu_en,
  output logic [3:0]  alu_mode,
  output logic        pc_jump,
  output logic        op2_from_dr,
  output logic        ctx_clear
);

  typedef enum logic [1:0] {PH_LOAD, PH_FETCH, PH_DECODE, PH_EXEC} phase_t;

  phase_t phase, phase_nx;

  logic in_load, in_fetch, in_decode, in_exec;
  logic cls_goto, cls_mem, cls_cond, cls_imm;
  logic flag_hit;

  assign in_load   = (phase == PH_LOAD);
  assign in_fetch  = (phase == PH_FETCH);
  assign in_decode = (phase == PH_DECODE);
  assign in_exec   = (phase == PH_EXEC);

  assign cls_goto = (ir[11:8] == 4'b0001);
  assign cls_mem  = (ir[11:9] == 3'b001);
  assign cls_cond = (ir[11:10] == 2'b01);
  assign cls_imm  = ir[11];

  always_comb begin
    case (ir[9:8])
      2'd0:    flag_hit = sr[3];
      2'd1:    flag_hit = sr[2];
      2'd2:    flag_hit = sr[1];
      default: flag_hit = sr[0];
    endcase
  end

  always_comb begin
    case (phase)
      PH_LOAD:   phase_nx = load_done ? PH_FETCH : PH_LOAD;
      PH_FETCH:  phase_nx = PH_DECODE;
      PH_DECODE: phase_nx = PH_EXEC;
      default:   phase_nx = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_LOAD;
    else     phase <= phase_nx;
  end

  assign prog_wr_en  = in_load;
  assign ctx_clear   = in_load & load_done;
  assign prog_rd_en  = in_load | in_fetch;
  assign ir_en       = in_fetch;
  assign dr_en       = in_decode & cls_mem;
  assign pc_en       = in_exec;
  assign pc_jump     = in_exec & (cls_goto | (cls_cond & flag_hit));
  assign alu_en      = in_exec & (cls_mem | cls_imm);
  assign flags_en    = alu_en;
  assign acc_en      = in_exec & (cls_imm | (cls_mem & ir[8]));
  assign dmem_we     = in_exec & cls_mem & ~ir[8];
  assign dmem_en     = (in_decode & cls_mem) | dmem_we;
  assign op2_from_dr = in_exec & cls_mem;

  always_comb begin
    alu_mode = 4'd0;
    if (in_exec && cls_mem)      alu_mode = ir[7:4];
    else if (in_exec && cls_imm) alu_mode = {1'b0, ir[10:8]};
  end

endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       load_done,
  input logic       prog_wr_en,
  input logic       prog_rd_en,
  input logic       pc_en,
  input logic       acc_en,
  input logic       flags_en,
  input logic       ir_en,
  input logic       dr_en,
  input logic       dmem_en,
  input logic       dmem_we,
  input logic       alu_en,
  input logic [3:0] alu_mode,
  input logic       pc_jump,
  input logic       op2_from_dr,
  input logic       ctx_clear
);

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    prog_wr_en |-> prog_rd_en && !ir_en && !pc_en && !alu_en && !dmem_en && !dr_en) // R2
  else $error("load phase drives a stray enable");

  AST_CLEAR_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    ctx_clear |=> ir_en && !prog_wr_en) // R2
  else $error("load done did not lead to fetch");

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    ir_en |=> !ir_en && !pc_en && !prog_wr_en) // R10
  else $error("fetch not followed by decode");

  AST_EXEC_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    pc_en |=> ir_en) // R10
  else $error("execute not followed by fetch");

  AST_WRITE_PATH: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> dmem_en && alu_en && op2_from_dr && !acc_en) // R8
  else $error("memory write without its companions");

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (rst)
    alu_en |-> (acc_en ^ dmem_we) && flags_en && pc_en) // R9
  else $error("ALU result needs exactly one destination");

  AST_IDLE_MODE: assert property (@(posedge clk) disable iff (rst)
    !alu_en |-> alu_mode == 4'd0 && !op2_from_dr) // R11
  else $error("unused ALU controls not zero");

  AST_JUMP_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
    pc_jump |-> pc_en && !alu_en) // R6
  else $error("jump select outside a branch execute");

endmodule

bind mcc_ctrl mcc_ctrl_chk u_chk (.*);

// File: tb/mcc_ctrl_tb.sv
module mcc_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_done = 1'b0;
  logic [11:0] ir = '0;
  logic [3:0] sr = '0;
  logic prog_wr_en, prog_rd_en, pc_en, acc_en, flags_en, ir_en, dr_en;
  logic dmem_en, dmem_we, alu_en, pc_jump, op2_from_dr, ctx_clear;
  logic [3:0] alu_mode;

  int total = 0;
  int bad = 0;
  int mst = 0;
  bit mvalid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcc_ctrl u_dut (.*);

  // vector: {wr, rd, pc, acc, flg, ir, dr, dme, dwe, alu, mode[3:0], jmp, op2, clr}
  function automatic logic [16:0] exp_vec(int st, logic [11:0] i, logic [3:0] s, logic ld);
    logic [16:0] v = '0;
    logic hit;
    case (i[9:8])
      2'd0: hit = s[3];
      2'd1: hit = s[2];
      2'd2: hit = s[1];
      default: hit = s[0];
    endcase
    if (st == 0) begin
      v[16] = 1; v[15] = 1; v[0] = ld;
    end else if (st == 1) begin
      v[15] = 1; v[11] = 1;
    end else if (st == 2) begin
      if (i[11:9] == 3'b001) begin v[10] = 1; v[9] = 1; end
    end else begin
      v[14] = 1;
      if (i[11]) begin
        v[13] = 1; v[12] = 1; v[7] = 1; v[6:3] = {1'b0, i[10:8]};
      end else if (i[11:9] == 3'b001) begin
        v[12] = 1; v[7] = 1; v[6:3] = i[7:4]; v[1] = 1;
        if (i[8]) v[13] = 1; else begin v[9] = 1; v[8] = 1; end
      end else if (i[11:10] == 2'b01) begin
        v[2] = hit;
      end else if (i[11:8] == 4'b0001) begin
        v[2] = 1;
      end
    end
    return v;
  endfunction

  function automatic string tag_of(int st, logic [11:0] i, logic ld);
    if (st == 0) return ld ? "R2" : "R1/R2";
    if (st == 1) return ld ? "R3/R10" : "R3";
    if (st == 2) return (i[11:9] == 3'b001) ? "R4" : "R4/R11";
    if (i[11]) return "R9";
    if (i[11:9] == 3'b001) return "R8";
    if (i[11:10] == 2'b01) return "R7";
    if (i[11:8] == 4'b0001) return "R6";
    return "R5/R11";
  endfunction

  task automatic step(logic ldv, logic [11:0] iv, logic [3:0] sv, logic rv);
    logic [16:0] act, expv;
    @(negedge clk);
    load_done = ldv; ir = iv; sr = sv; rst = rv;
    #1;
    if (mvalid) begin
      act = {prog_wr_en, prog_rd_en, pc_en, acc_en, flags_en, ir_en, dr_en,
             dmem_en, dmem_we, alu_en, alu_mode, pc_jump, op2_from_dr, ctx_clear};
      expv = exp_vec(mst, iv, sv, ldv);
      total++;
      if (act !== expv) begin
        bad++;
        $display("FAIL %s phase=%0d ir=%h sr=%h actual=%b expected=%b",
                 tag_of(mst, iv, ldv), mst, iv, sv, act, expv);
      end
    end
    @(posedge clk);
    if (rv) begin mst = 0; mvalid = 1; end
    else if (mvalid) begin
      if (mst == 0) mst = ldv ? 1 : 0;
      else mst = (mst == 3) ? 1 : mst + 1;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0de));
    step(0, 12'h000, 4'h0, 1);
    step(0, 12'h000, 4'h0, 1);
    // R1 R2: stay in load until the pulse, varied IR ignored
    for (int k = 0; k < 4; k++) step(0, 12'h3A5 + 12'(k), 4'hF, 0);
    step(1, 12'h000, 4'h0, 0);
    // R7: every flag code, taken and not taken
    for (int c = 0; c < 4; c++)
      for (int t = 0; t < 2; t++) begin
        logic [3:0] f = t[0] ? (4'b1000 >> c) : ~(4'b1000 >> c);
        for (int ph = 0; ph < 3; ph++) step(0, {2'b01, 2'(c), 8'h5A}, f, 0);
      end
    // R6 R5 R8 R9 directed
    for (int ph = 0; ph < 3; ph++) step(0, 12'h1F7, 4'h0, 0);
    for (int ph = 0; ph < 3; ph++) step(0, 12'h000, 4'hF, 0);
    for (int ph = 0; ph < 3; ph++) step(0, 12'h2E3, 4'h0, 0);
    for (int ph = 0; ph < 3; ph++) step(0, 12'h3B3, 4'h0, 0);
    for (int ph = 0; ph < 3; ph++) step(0, 12'hF08, 4'h0, 0);
    // R10: load_done pulses outside load are ignored
    for (int ph = 0; ph < 6; ph++) step(1, 12'h855, 4'h0, 0);
    // random mix with occasional reset and reload
    for (int n = 0; n < 3000; n++) begin
      logic rv = ($urandom_range(0, 199) == 0);
      logic ldv = ($urandom_range(0, 3) == 0);
      step(ldv, 12'($urandom()), 4'($urandom()), rv);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule